// File: doc/BRIEF.md
# Receive Character FIFO with Held Flush Request

This block buffers received characters between a producer that writes one character per clock and a consumer that pops them in arrival order. The head entry is always visible on the read data port, and an active-low empty flag tells the consumer whether that entry is valid. A clear-select input lets the path skip the buffer. While the buffer is skipped, the incoming character appears directly on the read data port and nothing is stored.

The buffer can be emptied by an active-low flush request, but only after a deliberate, held request. The request must be sampled low on a set number of consecutive clocks. On each of those clocks the chip enable must be active, the read enable inactive and the buffer selected. Once the flush begins, the empty flag drops at once, the read side and the occupancy are cleared, and the write pointer is cleared on the following clock. The buffer then refuses characters for as long as the request stays low. The empty flag stays low after release until a new character is written.

Top module: `rx_char_fifo`

## Requirements
- R1: After the asynchronous power-on reset, `empty_n` is 0 (empty).
- R2: Characters leave in the order they were written. While `empty_n` is 1, `rd_data` shows the oldest stored character, and a clock with `rd_en` high removes it.
- R3: `empty_n` rises on the clock edge that stores a character into an empty buffer. It falls on the edge that removes the last one.
- R4: A read while empty is ignored. `empty_n` stays 0, and the next written character is the one read out.
- R5: With DEPTH characters stored, further writes are discarded. The first DEPTH characters come out intact and then the buffer reports empty.
- R6: A flush starts on the clock edge of the QUAL_CYCLES-th (default 7) consecutive qualified sample. A qualified sample has `flush_n`=0, `ce_n`=0, `rd_en`=0 and `fifo_on`=1. `empty_n` is 0 from that edge. One sample fewer has no effect.
- R7: Any clock on which a qualifying condition is false restarts the count, so a full run of fresh qualified samples is needed again.
- R8: After a flush starts and while `flush_n` stays 0, writes are discarded and `empty_n` stays 0.
- R9: After `flush_n` returns to 1, `empty_n` stays 0 until a character is written. That character is the next one read, because the old contents are gone.
- R10: With `fifo_on`=0, the flush request is ignored, `rd_data` equals `wr_data`, and writes are not stored. The earlier contents remain readable once `fifo_on` returns to 1.
- R11: Occupancy never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| wr_data | input | WIDTH | Character to store |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read enable; pops the head entry |
| ce_n | input | 1 | Chip enable, active low |
| fifo_on | input | 1 | 1 selects the buffer, 0 skips it |
| flush_n | input | 1 | Flush request, active low |
| rd_data | output | WIDTH | Head entry, or `wr_data` when skipped |
| empty_n | output | 1 | 0 when no character is stored |

## Verification
The bench presents six qualified flush samples, breaks the run with an inactive chip enable, and then presents six more. A design that counted total low samples instead of consecutive ones would flush early. Another run proves the seventh sample alone starts the flush. A design that only cleared the read side would leak stale entries after release, and one that accepted writes while the request is held would raise the empty flag early; the bench writes during the hold and checks the first character after release. Reads from an empty buffer, writes into a full one, and a long held request while the buffer is skipped are each followed by readback of the stored order, which exposes wrapped pointers or a flush that ignored the select.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
   typedef enum logic [1:0] {
      RXF_RUN  = 2'd0,
      RXF_WIPE = 2'd1,
      RXF_HOLD = 2'd2
   } rxf_state_e;
endpackage

// File: rtl/rxf_flush_qual.sv
module rxf_flush_qual
   import rxf_pkg::*;
#(
   parameter int QUAL_CYCLES = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       flush_n,
   input  logic       fifo_on,
   input  logic       rd_en,
   input  logic       ce_n,
   output rxf_state_e state,
   output logic       start
);
   localparam int QW = $clog2(QUAL_CYCLES + 1);
   localparam logic [QW-1:0] LAST = QW'(QUAL_CYCLES - 1);

   logic [QW-1:0] qcnt_q;
   rxf_state_e    state_q;
   logic          qual_ok;

   assign qual_ok = !flush_n && fifo_on && !rd_en && !ce_n;
   assign start   = (state_q == RXF_RUN) && qual_ok && (qcnt_q == LAST);
   assign state   = state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RXF_RUN;
         qcnt_q  <= '0;
      end else begin
         unique case (state_q)
            RXF_RUN: begin
               if (start) begin
                  state_q <= RXF_WIPE;
                  qcnt_q  <= '0;
               end else if (qual_ok) begin
                  qcnt_q  <= qcnt_q + 1'b1;
               end else begin
                  qcnt_q  <= '0;
               end
            end
            RXF_WIPE: begin
               state_q <= flush_n ? RXF_RUN : RXF_HOLD;
               qcnt_q  <= '0;
            end
            RXF_HOLD: begin
               if (flush_n) state_q <= RXF_RUN;
               qcnt_q <= '0;
            end
            default: begin
               state_q <= RXF_RUN;
               qcnt_q  <= '0;
            end
         endcase
      end
   end
endmodule

// File: rtl/rxf_ptr_ctrl.sv
module rxf_ptr_ctrl
   import rxf_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int FW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  rxf_state_e    state,
   input  logic          start,
   input  logic          push_req,
   input  logic          pop_req,
   output logic [PW-1:0] wr_ptr,
   output logic [PW-1:0] rd_ptr,
   output logic [FW-1:0] fill,
   output logic          empty_n,
   output logic          push,
   output logic          pop
);
   localparam logic [FW-1:0] FULL_LVL = FW'(DEPTH);

   logic [PW-1:0] wr_q, rd_q, wr_inc, rd_inc;
   logic [FW-1:0] fill_q, fill_nxt;
   logic          empty_n_q;
   logic          running;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_inc = wr_q + 1'b1;
         assign rd_inc = rd_q + 1'b1;
      end else begin : g_wrap
         assign wr_inc = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
         assign rd_inc = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      end
   endgenerate

   assign running = (state == RXF_RUN) && !start;
   assign push    = running && push_req && (fill_q != FULL_LVL);
   assign pop     = running && pop_req && (fill_q != '0);

   always_comb begin
      fill_nxt = fill_q;
      if (start)
         fill_nxt = '0;
      else if (push && !pop)
         fill_nxt = fill_q + 1'b1;
      else if (pop && !push)
         fill_nxt = fill_q - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q      <= '0;
         rd_q      <= '0;
         fill_q    <= '0;
         empty_n_q <= 1'b0;
      end else begin
         fill_q    <= fill_nxt;
         empty_n_q <= (fill_nxt != '0);
         if (start)
            rd_q <= '0;
         else if (pop)
            rd_q <= rd_inc;
         if (state == RXF_WIPE)
            wr_q <= '0;
         else if (push)
            wr_q <= wr_inc;
      end
   end

   assign wr_ptr  = wr_q;
   assign rd_ptr  = rd_q;
   assign fill    = fill_q;
   assign empty_n = empty_n_q;
endmodule

// File: rtl/rxf_store.sv
module rxf_store #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 16,
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             we,
   input  logic [PW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [PW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);
   logic [WIDTH-1:0] mem_q [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_entry
         always_ff @(posedge clk) begin
            if (we && (waddr == PW'(i)))
               mem_q[i] <= wdata;
         end
      end
   endgenerate

   assign rdata = mem_q[raddr];
endmodule

// File: rtl/rx_char_fifo.sv
module rx_char_fifo
   import rxf_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int DEPTH       = 16,
   parameter int QUAL_CYCLES = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic             ce_n,
   input  logic             fifo_on,
   input  logic             flush_n,
   output logic [WIDTH-1:0] rd_data,
   output logic             empty_n
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int FW = $clog2(DEPTH + 1);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("rx_char_fifo: WIDTH must be at least 1");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("rx_char_fifo: DEPTH must be at least 2");
      end
      if (QUAL_CYCLES < 1) begin : g_bad_qual
         $error("rx_char_fifo: QUAL_CYCLES must be at least 1");
      end
   endgenerate

   rxf_state_e       state;
   logic             start;
   logic [PW-1:0]    wr_ptr, rd_ptr;
   logic [FW-1:0]    fill;
   logic             push, pop;
   logic [WIDTH-1:0] mem_rd;

   rxf_flush_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush_n (flush_n),
      .fifo_on (fifo_on),
      .rd_en   (rd_en),
      .ce_n    (ce_n),
      .state   (state),
      .start   (start)
   );

   rxf_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .state    (state),
      .start    (start),
      .push_req (wr_en && fifo_on),
      .pop_req  (rd_en && fifo_on),
      .wr_ptr   (wr_ptr),
      .rd_ptr   (rd_ptr),
      .fill     (fill),
      .empty_n  (empty_n),
      .push     (push),
      .pop      (pop)
   );

   rxf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
      .clk   (clk),
      .we    (push),
      .waddr (wr_ptr),
      .wdata (wr_data),
      .raddr (rd_ptr),
      .rdata (mem_rd)
   );

   assign rd_data = fifo_on ? mem_rd : wr_data;
endmodule

// File: rtl/rx_char_fifo_chk.sv
module rx_char_fifo_chk
   import rxf_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int FW = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input rxf_state_e    state,
   input logic          start,
   input logic [FW-1:0] fill,
   input logic          empty_n,
   input logic          push,
   input logic          wr_en,
   input logic          rd_en,
   input logic          fifo_on
);
   a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= FW'(DEPTH));

   a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !empty_n);

   a_r8_no_store_when_held: assert property (@(posedge clk) disable iff (!rst_n)
      (state != RXF_RUN) |-> !push);

   a_r10_skip_ignores_flush: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_on |-> !start);

   a_r4_empty_read_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (fill == '0 && rd_en && !(wr_en && fifo_on)) |=> (fill == '0));

   a_r9_empty_until_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!empty_n && !push) |=> !empty_n);

   a_r3_store_raises_flag: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> empty_n);
endmodule

bind rx_char_fifo rx_char_fifo_chk #(.DEPTH(DEPTH)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .state   (state),
   .start   (start),
   .fill    (fill),
   .empty_n (empty_n),
   .push    (push),
   .wr_en   (wr_en),
   .rd_en   (rd_en),
   .fifo_on (fifo_on)
);

// File: tb/tb_rx_char_fifo.sv
`timescale 1ns/1ps
module tb_rx_char_fifo;
   localparam int W = 8;
   localparam int D = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic         wr_en = 1'b0, rd_en = 1'b0, ce_n = 1'b1, fifo_on = 1'b1, flush_n = 1'b1;
   logic [W-1:0] rd_data;
   logic         empty_n;
   int           n_chk = 0, n_err = 0;

   always #5 clk = ~clk;

   rx_char_fifo #(.WIDTH(W), .DEPTH(D), .QUAL_CYCLES(7)) dut (
      .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_en(wr_en), .rd_en(rd_en),
      .ce_n(ce_n), .fifo_on(fifo_on), .flush_n(flush_n), .rd_data(rd_data), .empty_n(empty_n)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic put(input logic [W-1:0] d);
      wr_data = d; wr_en = 1'b1; cyc(); wr_en = 1'b0;
   endtask

   task automatic take(input logic [W-1:0] exp, input string tag);
      chk({tag, " head"}, rd_data, exp);
      rd_en = 1'b1; cyc(); rd_en = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 empty after reset", empty_n, 0);
   endtask

   task automatic t_order();
      put(8'hA0);
      chk("R3 flag rises on first store", empty_n, 1);
      put(8'hA1); put(8'hA2);
      take(8'hA0, "R2 first"); take(8'hA1, "R2 second"); take(8'hA2, "R2 third");
      chk("R3 flag falls on last pop", empty_n, 0);
   endtask

   task automatic t_empty_read();
      rd_en = 1'b1; cyc(); cyc(); rd_en = 1'b0;
      chk("R4 empty read keeps flag low", empty_n, 0);
      put(8'h55);
      chk("R4 flag after write", empty_n, 1);
      take(8'h55, "R4 written char");
      chk("R4 empty again", empty_n, 0);
   endtask

   task automatic t_full();
      for (int i = 0; i < D + 3; i++) put(W'(8'h10 + i));
      for (int i = 0; i < D; i++) take(W'(8'h10 + i), "R5 full readback");
      chk("R5 extra writes discarded", empty_n, 0);
   endtask

   task automatic t_flush();
      put(8'hB0); put(8'hB1);
      ce_n = 1'b0; flush_n = 1'b0;
      repeat (6) cyc();
      chk("R6 six samples no flush", empty_n, 1);
      ce_n = 1'b1; cyc(); ce_n = 1'b0;
      repeat (6) cyc();
      chk("R7 broken run restarts count", empty_n, 1);
      chk("R7 contents intact", rd_data, 8'hB0);
      cyc();
      chk("R6 seventh sample flushes", empty_n, 0);
      wr_data = 8'hC5; wr_en = 1'b1; cyc(); cyc(); cyc(); wr_en = 1'b0;
      chk("R8 held flush refuses writes", empty_n, 0);
      flush_n = 1'b1; ce_n = 1'b1; cyc();
      chk("R9 empty after release", empty_n, 0);
      cyc();
      chk("R9 still empty without write", empty_n, 0);
      put(8'hD7);
      chk("R9 flag after new write", empty_n, 1);
      take(8'hD7, "R9 new char first");
      chk("R9 old contents gone", empty_n, 0);
   endtask

   task automatic t_bypass();
      put(8'hE0); put(8'hE1);
      fifo_on = 1'b0; ce_n = 1'b0; flush_n = 1'b0;
      wr_data = 8'h3C; wr_en = 1'b1;
      #1 chk("R10 passthrough data", rd_data, 8'h3C);
      repeat (10) cyc();
      wr_data = 8'h4D;
      #1 chk("R10 passthrough follows input", rd_data, 8'h4D);
      wr_en = 1'b0; flush_n = 1'b1; ce_n = 1'b1; cyc();
      fifo_on = 1'b1;
      #1 chk("R10 flush ignored", empty_n, 1);
      take(8'hE0, "R10 kept first"); take(8'hE1, "R10 kept second");
      chk("R10 skipped writes not stored", empty_n, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_order();
      t_empty_read();
      t_full();
      t_flush();
      t_bypass();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog all requirements actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule